// File: doc/BRIEF.md
# UART Receive Idle-Timeout Flag

This block sits beside a UART receiver and its receive FIFO. It reports leftover receive data that would otherwise wait unnoticed: the FIFO holds some bytes, but fewer than the level that raises the receive interrupt, and the line has gone quiet. A small counter measures the silence in bit times. The counter starts again whenever the receiver reports that a stop bit has finished. When it has seen fifteen bit times, the flag is raised. With eight data bits and one stop bit, that window is one and a half frames.

The flag works only in asynchronous mode. Software clears it with a handshake. First it reads the flag as 1. Then it drains the FIFO. Then it writes 0. A DMA engine clears the flag as a side effect when it reads out the last byte. Both a power-on reset and a manual reset drop the flag.

Top module: `rx_idle_flag`

## Requirements
- R1: With `async_mode` = 0 (clocked synchronous mode) the flag never rises. With `async_mode` = 1 it may rise.
- R2: The flag rises only when `fifo_count` is nonzero and strictly less than `trig_level`.
- R3: The idle window is counted from the last `stop_done` cycle, and only `bit_tick` pulses advance it. After 15 tick cycles the flag is 1 following one further clock edge. After 14 tick cycles plus one further edge it is still 0.
- R4: `stop_done` restarts the window from zero and blocks a rise in its own cycle. The count saturates at 15: once it is saturated, the flag rises on the next edge after `fifo_count` drops below `trig_level`, with no further ticks needed.
- R5: The flag is 0 after `rst_n` is asserted low (asynchronous). It is also 0 on the edge after a cycle with `mrst` = 1 (synchronous). Either reset also restarts the window.
- R6: A CPU write with `cpu_wr_data` = 1 never changes the flag. A write of 0 without a prior read of 1, or while `fifo_count` is nonzero, leaves the flag at 1.
- R7: A cycle with `cpu_flag_rd` = 1 while the flag is 1 records the read. After that, a write of 0 (`cpu_wr_en` = 1, `cpu_wr_data` = 0) while `fifo_count` = 0 clears the flag on that edge.
- R8: A cycle with `dma_rd` = 1 while `fifo_count` = 1 (the DMA takes the last byte) clears the flag. A DMA read while `fifo_count` = 2 does not clear it.
- R9: A clear outranks a set in the same cycle. Any clear restarts the window, so the flag rises again only after another 15 ticks.
- R10: The recorded read is dropped whenever the flag is 0. After a clear and a new rise, a write of 0 with an empty FIFO does not clear the flag until the flag has been read as 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mrst | input | 1 | Synchronous manual reset, active high |
| async_mode | input | 1 | 1 = asynchronous mode, 0 = clocked synchronous mode |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| stop_done | input | 1 | One-cycle pulse when a received byte's stop bit completes |
| fifo_count | input | CNT_W | Bytes currently held in the receive FIFO |
| trig_level | input | CNT_W | Receive interrupt trigger count |
| cpu_flag_rd | input | 1 | CPU reads the flag register this cycle |
| cpu_wr_en | input | 1 | CPU writes the flag register this cycle |
| cpu_wr_data | input | 1 | Value written to the flag |
| dma_rd | input | 1 | DMA pops one byte from the FIFO this cycle |
| ready_flag | output | 1 | Leftover-data-ready flag |

## Verification
The assertions assume the following about the inputs:
- `fifo_count` is the FIFO occupancy before any pop in the same cycle, so a DMA pop at a count of 1 empties the FIFO.
- `bit_tick` and `stop_done` are single-cycle strobes.
- `mrst` is a synchronous level.

The bench drives the FIFO count as a free variable rather than modelling the FIFO. It only issues DMA pops and clearing writes at counts that a real FIFO could show. All inputs change two nanoseconds after a rising edge and are held for whole cycles, so no strobe is shorter than a clock.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;

    // Registered state of the flag controller
    typedef struct packed {
        logic flag;     // data-ready flag visible to software
        logic rd_seen;  // software has read the flag as 1
    } flag_state_t;

endpackage

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
    parameter int IDLE_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_BITS);

    logic [CW-1:0] cnt_d, cnt_q;

    // Next count: restart wins, otherwise advance on tick and hold at LIMIT
    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != LIMIT)) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == LIMIT);

endmodule

// File: rtl/rx_idle_flagctl.sv
module rx_idle_flagctl
    import rx_idle_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrst,
    input  logic             async_mode,
    input  logic             stop_done,
    input  logic             expired,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             cpu_flag_rd,
    input  logic             cpu_wr_en,
    input  logic             cpu_wr_data,
    input  logic             dma_rd,
    output logic             clear,
    output logic             flag,
    output logic             rd_seen
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    flag_state_t st_d, st_q;
    logic        below_trig;
    logic        set_cond;
    logic        wr_clear;
    logic        dma_clear;

    always_comb begin
        below_trig = (fifo_count != '0) && (fifo_count < trig_level);
        set_cond   = async_mode && below_trig && expired && !stop_done;
        wr_clear   = cpu_wr_en && !cpu_wr_data && st_q.rd_seen && (fifo_count == '0);
        dma_clear  = dma_rd && (fifo_count == ONE);
        clear      = wr_clear || dma_clear;

        st_d = st_q;
        if (mrst) begin
            st_d = '0;
        end else begin
            // A clear overrides a set in the same cycle
            if (clear) begin
                st_d.flag = 1'b0;
            end else if (set_cond) begin
                st_d.flag = 1'b1;
            end
            // Record a read only while the flag stays set
            if (!st_d.flag) begin
                st_d.rd_seen = 1'b0;
            end else if (cpu_flag_rd && st_q.flag) begin
                st_d.rd_seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag    = st_q.flag;
    assign rd_seen = st_q.rd_seen;

endmodule

// File: rtl/rx_idle_flag.sv
module rx_idle_flag #(
    parameter int CNT_W     = 5,
    parameter int IDLE_BITS = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrst,
    input  logic             async_mode,
    input  logic             bit_tick,
    input  logic             stop_done,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             cpu_flag_rd,
    input  logic             cpu_wr_en,
    input  logic             cpu_wr_data,
    input  logic             dma_rd,
    output logic             ready_flag
);
    logic idle_expired;
    logic flag_clear;
    logic rd_seen;
    logic win_restart;

    // Any reset, new byte or flag clear starts a fresh window
    assign win_restart = mrst || stop_done || flag_clear;

    rx_idle_timer #(
        .IDLE_BITS(IDLE_BITS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(win_restart),
        .tick   (bit_tick),
        .expired(idle_expired)
    );

    rx_idle_flagctl #(
        .CNT_W(CNT_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mrst       (mrst),
        .async_mode (async_mode),
        .stop_done  (stop_done),
        .expired    (idle_expired),
        .fifo_count (fifo_count),
        .trig_level (trig_level),
        .cpu_flag_rd(cpu_flag_rd),
        .cpu_wr_en  (cpu_wr_en),
        .cpu_wr_data(cpu_wr_data),
        .dma_rd     (dma_rd),
        .clear      (flag_clear),
        .flag       (ready_flag),
        .rd_seen    (rd_seen)
    );

endmodule

// File: rtl/rx_idle_flag_chk.sv
module rx_idle_flag_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mrst,
    input logic             async_mode,
    input logic             stop_done,
    input logic [CNT_W-1:0] fifo_count,
    input logic [CNT_W-1:0] trig_level,
    input logic             cpu_wr_en,
    input logic             cpu_wr_data,
    input logic             dma_rd,
    input logic             idle_expired,
    input logic             rd_seen,
    input logic             ready_flag
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    p_sync_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_flag && !async_mode) |=> !ready_flag);

    p_rise_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_flag) |-> $past((fifo_count != '0) && (fifo_count < trig_level)));

    p_rise_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_flag) |-> $past(idle_expired));

    p_stop_norise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_done && !ready_flag) |=> !ready_flag);

    p_mrst_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> !ready_flag);

    p_wr1_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_flag && cpu_wr_en && cpu_wr_data && !mrst && !(dma_rd && fifo_count == ONE))
        |=> ready_flag);

    p_wr0_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_flag && cpu_wr_en && !cpu_wr_data && rd_seen && fifo_count == '0) |=> !ready_flag);

    p_dma_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd && fifo_count == ONE) |=> !ready_flag);

    p_seen_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_flag |-> !rd_seen);

endmodule

bind rx_idle_flag rx_idle_flag_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mrst        (mrst),
    .async_mode  (async_mode),
    .stop_done   (stop_done),
    .fifo_count  (fifo_count),
    .trig_level  (trig_level),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_wr_data (cpu_wr_data),
    .dma_rd      (dma_rd),
    .idle_expired(idle_expired),
    .rd_seen     (rd_seen),
    .ready_flag  (ready_flag)
);

// File: tb/rx_idle_flag_bench.sv
`timescale 1ns/1ps
module rx_idle_flag_bench;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mrst = 1'b0;
    logic             async_mode = 1'b1;
    logic             bit_tick = 1'b0;
    logic             stop_done = 1'b0;
    logic [CNT_W-1:0] fifo_count = '0;
    logic [CNT_W-1:0] trig_level = '0;
    logic             cpu_flag_rd = 1'b0;
    logic             cpu_wr_en = 1'b0;
    logic             cpu_wr_data = 1'b0;
    logic             dma_rd = 1'b0;
    logic             ready_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rx_idle_flag #(.CNT_W(CNT_W)) u_rx_idle_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .mrst       (mrst),
        .async_mode (async_mode),
        .bit_tick   (bit_tick),
        .stop_done  (stop_done),
        .fifo_count (fifo_count),
        .trig_level (trig_level),
        .cpu_flag_rd(cpu_flag_rd),
        .cpu_wr_en  (cpu_wr_en),
        .cpu_wr_data(cpu_wr_data),
        .dma_rd     (dma_rd),
        .ready_flag (ready_flag)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Vector row: {mrst, async, stop, ticks[4:0], count[4:0], trig[4:0], expected flag}
    localparam int NV = 8;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b1, 5'd15, 5'd3, 5'd8, 1'b1},  // R3 full window
        {1'b1, 1'b1, 1'b1, 5'd14, 5'd3, 5'd8, 1'b0},  // R3 one tick short
        {1'b1, 1'b0, 1'b1, 5'd15, 5'd3, 5'd8, 1'b0},  // R1 synchronous mode
        {1'b1, 1'b1, 1'b1, 5'd15, 5'd8, 5'd8, 1'b0},  // R2 count equal to trigger
        {1'b1, 1'b1, 1'b1, 5'd15, 5'd0, 5'd8, 1'b0},  // R2 empty FIFO
        {1'b1, 1'b1, 1'b1, 5'd15, 5'd7, 5'd8, 1'b1},  // R2 one below trigger
        {1'b1, 1'b1, 1'b1, 5'd20, 5'd1, 5'd2, 1'b1},  // R4 extra ticks saturate
        {1'b0, 1'b1, 1'b1, 5'd10, 5'd1, 5'd2, 1'b1}   // R3 set flag persists
    };

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic run_ticks(input int n);
        bit_tick = 1'b1;
        repeat (n) cyc();
        bit_tick = 1'b0;
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (ready_flag !== exp) begin
            errors++;
            $display("FAIL %s: ready_flag=%0b expected %0b", req, ready_flag, exp);
        end
    endtask

    task automatic pulse_stop();
        stop_done = 1'b1;
        cyc();
        stop_done = 1'b0;
    endtask

    task automatic do_mrst();
        mrst = 1'b1;
        cyc();
        mrst = 1'b0;
    endtask

    // Fresh window with the given occupancy, then a full silence
    task automatic arm(input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] trg);
        fifo_count = cnt;
        trig_level = trg;
        pulse_stop();
        run_ticks(15);
        cyc();
    endtask

    initial begin
        #20;
        check("R5 power-on reset", 1'b0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        cyc();
        check("R5 after reset release", 1'b0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][18]) do_mrst();
            async_mode = VEC[i][17];
            fifo_count = VEC[i][10:6];
            trig_level = VEC[i][5:1];
            if (VEC[i][16]) pulse_stop();
            run_ticks(int'(VEC[i][15:11]));
            cyc();
            check($sformatf("vector %0d", i), VEC[i][0]);
        end

        // R5 manual reset drops a set flag
        check("R5 flag set before mrst", 1'b1);
        do_mrst();
        check("R5 manual reset", 1'b0);

        // R4 stop_done restarts the window
        do_mrst();
        fifo_count = 5'd2;
        trig_level = 5'd4;
        pulse_stop();
        run_ticks(10);
        pulse_stop();
        run_ticks(10);
        cyc();
        check("R4 restart after stop", 1'b0);
        run_ticks(5);
        cyc();
        check("R4 window done after restart", 1'b1);

        // R4 saturated count: a drop below trigger sets without further ticks
        do_mrst();
        fifo_count = 5'd4;
        trig_level = 5'd4;
        pulse_stop();
        run_ticks(20);
        cyc();
        check("R4 at trigger, no set", 1'b0);
        fifo_count = 5'd3;
        cyc();
        check("R4 saturated count sets at once", 1'b1);

        // R6 and R7 software handshake
        fifo_count = 5'd0;
        cpu_wr_en = 1'b1;
        cpu_wr_data = 1'b0;
        cyc();
        cpu_wr_en = 1'b0;
        check("R6 write 0 without read", 1'b1);
        cpu_flag_rd = 1'b1;
        cyc();
        cpu_flag_rd = 1'b0;
        fifo_count = 5'd2;
        cpu_wr_en = 1'b1;
        cyc();
        cpu_wr_en = 1'b0;
        check("R6 write 0 with FIFO not empty", 1'b1);
        fifo_count = 5'd0;
        cpu_wr_en = 1'b1;
        cpu_wr_data = 1'b1;
        cyc();
        check("R6 write 1 ignored", 1'b1);
        cpu_wr_data = 1'b0;
        cyc();
        cpu_wr_en = 1'b0;
        check("R7 write 0 after read and drain", 1'b0);

        // R10 the recorded read does not survive a clear
        arm(5'd3, 5'd8);
        check("R10 flag set again", 1'b1);
        fifo_count = 5'd0;
        cpu_wr_en = 1'b1;
        cyc();
        cpu_wr_en = 1'b0;
        check("R10 old read discarded", 1'b1);

        // R8 DMA pop at a count of 2 keeps the flag
        do_mrst();
        arm(5'd2, 5'd4);
        check("R8 flag set", 1'b1);
        dma_rd = 1'b1;
        cyc();
        dma_rd = 1'b0;
        check("R8 DMA pop not last", 1'b1);

        // R8/R9 last-byte DMA pop clears even though set condition holds
        fifo_count = 5'd1;
        dma_rd = 1'b1;
        cyc();
        dma_rd = 1'b0;
        check("R8 DMA drain clears, R9 clear wins", 1'b0);
        run_ticks(14);
        cyc();
        check("R9 no set before fresh window", 1'b0);
        run_ticks(1);
        cyc();
        check("R9 set after fresh window", 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule